// File: doc/BRIEF.md
# Burst Size Splitter for a Restricted Memory Interface

This block sits between a stage that builds memory burst commands on a 128-bit data path and a downstream memory interface that takes only a limited set of burst lengths. Upstream commands carry 2, 4, 6 or 8 beats of 128 bits; the largest is 8 beats, or 128 bytes. The downstream side accepts 1, 2, 4 or 8 beats. Commands of 2, 4 or 8 beats go through unchanged. A 6-beat command has no downstream encoding, so it is reissued as a 4-beat command followed by a 2-beat command. The second command starts 64 bytes above the first.

Both sides use a valid/ready handshake. Each command carries a direction bit and two frame tags: start-of-frame, used on reads, and end-of-frame, used on writes. The block handles commands only. It stores no data and does no arbitration.

Top module: `bsplit_top`

## Requirements
- R1: When reset is low at a clock edge, the block comes out of that edge with `out_valid` low and `in_ready` high, and any command it held is dropped.
- R2: A command with `in_len` of 2, 4 or 8 is accepted when `in_valid` and `in_ready` are both high at an edge. It is presented after that same edge as a single downstream command. Its address, length, direction, start-of-frame and end-of-frame match the accepted command.
- R3: A command with `in_len` equal to 6 is presented as two downstream commands, in this order: first `out_len`=4 at the original address, then `out_len`=2 at the original address plus 64. The address addition wraps modulo 2^ADDR_W.
- R4: Whenever `out_valid` is high, `out_len` holds 1, 2, 4 or 8. The length fields carry the beat count as a plain binary number.
- R5: `in_ready` is low while the first part of a split command is still pending, whatever the state of `out_ready`. `in_ready` is also low while any presented command is stalled by a low `out_ready`.
- R6: Both parts of a split command carry the original direction bit and start-of-frame bit. End-of-frame is 0 on the first part and equals the original end-of-frame on the second part.
- R7: While `out_valid` is high and `out_ready` is low, the presented command does not change at the next edge.
- R8: In a cycle where the final pending part is accepted downstream, `in_ready` is high. A new command is then taken in that cycle and presented after the same edge, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Upstream command valid |
| in_ready | output | 1 | Block can take an upstream command |
| in_addr | input | ADDR_W | Byte address of the upstream command |
| in_len | input | LEN_W | Upstream beat count (2, 4, 6 or 8) |
| in_write | input | 1 | 1 for write, 0 for read |
| in_sof | input | 1 | Start-of-frame tag |
| in_eof | input | 1 | End-of-frame tag |
| out_valid | output | 1 | Downstream command valid |
| out_ready | input | 1 | Downstream interface takes the command |
| out_addr | output | ADDR_W | Byte address of the downstream command |
| out_len | output | LEN_W | Downstream beat count (1, 2, 4 or 8) |
| out_write | output | 1 | Direction of the downstream command |
| out_sof | output | 1 | Start-of-frame tag on the downstream command |
| out_eof | output | 1 | End-of-frame tag on the downstream command |

## Verification
The command accepted at one edge is presented at the output right after that edge. The bench therefore drives its inputs at a falling edge and reads the first or only part at the next falling edge. When `out_ready` is high, the second part of a split appears one cycle later, and `out_valid` drops one cycle after the last part is taken. The bench samples each of these at the falling edge of the cycle in which it is due. `in_ready` is combinational on the current state and `out_ready`, so it is sampled in the same half-cycle that the bench changes `out_ready`. Stall tests hold `out_ready` low for several cycles and compare the presented command on each one.

// File: rtl/bsplit_pkg.sv
// Package: shared types for the burst splitter.
// Assumes: nothing beyond IEEE 1800-2017.
package bsplit_pkg;

    // Phase of the held command: nothing held, a whole command,
    // the first part of a split, or the second part of a split.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WHOLE = 2'd1,
        PH_HEAD  = 2'd2,
        PH_TAIL  = 2'd3
    } phase_t;

    // Beat counts that take part in the split rule.
    localparam int SPLIT_BEATS = 6;
    localparam int HEAD_BEATS  = 4;
    localparam int TAIL_BEATS  = 2;

endpackage

// File: rtl/bsplit_plan.sv
// Module: bsplit_plan
// Purely combinational. Looks at one upstream command and decides whether
// it must be split. If so, it gives the lengths of both parts and the start
// address of the second part.
// Assumes: in_len carries a plain beat count; the beat width is BEAT_BYTES bytes.
module bsplit_plan #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 4,
    parameter int BEAT_BYTES = 16
) (
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    output logic              need_split,
    output logic [LEN_W-1:0]  head_len,
    output logic [LEN_W-1:0]  tail_len,
    output logic [ADDR_W-1:0] tail_addr
);
    import bsplit_pkg::*;

    localparam int          TAIL_OFS_BYTES = HEAD_BEATS * BEAT_BYTES;
    localparam logic [ADDR_W-1:0] TAIL_OFS = ADDR_W'(TAIL_OFS_BYTES);
    localparam logic [LEN_W-1:0]  L_SPLIT  = LEN_W'(SPLIT_BEATS);
    localparam logic [LEN_W-1:0]  L_HEAD   = LEN_W'(HEAD_BEATS);
    localparam logic [LEN_W-1:0]  L_TAIL   = LEN_W'(TAIL_BEATS);

    // Classify the command and pick the lengths of its parts.
    always_comb begin
        need_split = (cmd_len == L_SPLIT);
        head_len   = need_split ? L_HEAD : cmd_len;
        tail_len   = L_TAIL;
    end

    // Second-part address: one head burst above the start, wrapping.
    always_comb begin
        tail_addr = cmd_addr + TAIL_OFS;
    end

    // Lengths sent on must be legal whenever the split rule applies.
    always_comb begin
        if (need_split) begin
            AST_PLAN_PARTS: assert ((head_len + tail_len) == cmd_len)   // R3
                else $error("split parts do not sum to the original length");
        end
    end

endmodule

// File: rtl/bsplit_stage.sv
// Module: bsplit_stage
// Holds one command and presents it downstream. A split command is
// presented as its first part, then its second part. The stage takes a
// new command when it is empty, or in the same cycle that the final part
// is accepted downstream.
// Assumes: the plan inputs are valid together with the in_* command; the
// upstream side only issues 2, 4, 6 or 8 beats.
module bsplit_stage #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 4,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_write,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              plan_split,
    input  logic [LEN_W-1:0]  plan_head_len,
    input  logic [LEN_W-1:0]  plan_tail_len,
    input  logic [ADDR_W-1:0] plan_tail_addr,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_write,
    output logic              out_sof,
    output logic              out_eof
);
    import bsplit_pkg::*;

    localparam logic [ADDR_W-1:0] TAIL_OFS = ADDR_W'(HEAD_BEATS * BEAT_BYTES);

    phase_t            phase_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LEN_W-1:0]  cur_len_q;
    logic [ADDR_W-1:0] tail_addr_q;
    logic [LEN_W-1:0]  tail_len_q;
    logic              write_q;
    logic              sof_q;
    logic              eof_q;
    logic              last_part;
    logic              out_fire;
    logic              in_fire;

    // Handshake decode for the current cycle.
    always_comb begin
        last_part = (phase_q == PH_WHOLE) || (phase_q == PH_TAIL);
        out_fire  = out_valid && out_ready;
        in_ready  = (phase_q == PH_IDLE) || (out_ready && last_part);
        in_fire   = in_valid && in_ready;
    end

    // Phase sequencing: load, advance head to tail, or drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else if (in_fire) begin
            phase_q <= plan_split ? PH_HEAD : PH_WHOLE;
        end else if (out_fire) begin
            phase_q <= (phase_q == PH_HEAD) ? PH_TAIL : PH_IDLE;
        end
    end

    // Command fields: load on accept, swap in second part after the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr_q  <= '0;
            cur_len_q   <= '0;
            tail_addr_q <= '0;
            tail_len_q  <= '0;
            write_q     <= 1'b0;
            sof_q       <= 1'b0;
            eof_q       <= 1'b0;
        end else if (in_fire) begin
            cur_addr_q  <= in_addr;
            cur_len_q   <= plan_head_len;
            tail_addr_q <= plan_tail_addr;
            tail_len_q  <= plan_tail_len;
            write_q     <= in_write;
            sof_q       <= in_sof;
            eof_q       <= in_eof;
        end else if (out_fire && (phase_q == PH_HEAD)) begin
            cur_addr_q  <= tail_addr_q;
            cur_len_q   <= tail_len_q;
        end
    end

    // Downstream view; end-of-frame is withheld from the first part.
    always_comb begin
        out_valid = (phase_q != PH_IDLE);
        out_addr  = cur_addr_q;
        out_len   = cur_len_q;
        out_write = write_q;
        out_sof   = sof_q;
        out_eof   = eof_q && (phase_q != PH_HEAD);
    end

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_len == 1 || out_len == 2 || out_len == 4 || out_len == 8))   // R4
        else $error("illegal downstream length");

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_len)
                                       && $stable(out_write) && $stable(out_sof) && $stable(out_eof)))   // R7
        else $error("stalled command changed");

    AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready)   // R5
        else $error("input accepted during a stall");

    AST_TAIL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_len == 4 && !in_ready)
            |=> (out_valid && out_len == 2 && out_addr == $past(out_addr) + TAIL_OFS
                 && out_write == $past(out_write) && out_sof == $past(out_sof)))   // R3
        else $error("second part wrong after first part");

    AST_SPLIT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_len == 6)
            |=> (out_valid && out_len == 4 && !out_eof && !in_ready
                 && out_addr == $past(in_addr)))   // R6
        else $error("first part of split wrong");

endmodule

// File: rtl/bsplit_top.sv
// Module: bsplit_top
// Reissues upstream bursts as lengths the downstream interface accepts.
// It decodes the split on the input side and holds the command in one
// stage that presents it downstream.
// Assumes: 128-bit beats (16 bytes each); upstream lengths 2, 4, 6 or 8.
module bsplit_top #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 4,
    parameter int BEAT_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [LEN_W-1:0]  in_len,
    input  logic              in_write,
    input  logic              in_sof,
    input  logic              in_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_write,
    output logic              out_sof,
    output logic              out_eof
);
    logic              plan_split;
    logic [LEN_W-1:0]  plan_head_len;
    logic [LEN_W-1:0]  plan_tail_len;
    logic [ADDR_W-1:0] plan_tail_addr;

    bsplit_plan #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .BEAT_BYTES(BEAT_BYTES)
    ) u_plan (
        .cmd_addr  (in_addr),
        .cmd_len   (in_len),
        .need_split(plan_split),
        .head_len  (plan_head_len),
        .tail_len  (plan_tail_len),
        .tail_addr (plan_tail_addr)
    );

    bsplit_stage #(
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W),
        .BEAT_BYTES(BEAT_BYTES)
    ) u_stage (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_addr       (in_addr),
        .in_len        (in_len),
        .in_write      (in_write),
        .in_sof        (in_sof),
        .in_eof        (in_eof),
        .plan_split    (plan_split),
        .plan_head_len (plan_head_len),
        .plan_tail_len (plan_tail_len),
        .plan_tail_addr(plan_tail_addr),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_addr      (out_addr),
        .out_len       (out_len),
        .out_write     (out_write),
        .out_sof       (out_sof),
        .out_eof       (out_eof)
    );

    AST_PASS_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_len != 6)
            |=> (out_valid && out_len == $past(in_len) && out_addr == $past(in_addr)
                 && out_eof == $past(in_eof)))   // R2
        else $error("whole command altered");

endmodule

// File: tb/tb_bsplit_top.sv
module tb_bsplit_top;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 4;
    localparam int NV     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [LEN_W-1:0]  in_len = '0;
    logic              in_write = 1'b0;
    logic              in_sof = 1'b0;
    logic              in_eof = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [ADDR_W-1:0] out_addr;
    logic [LEN_W-1:0]  out_len;
    logic              out_write;
    logic              out_sof;
    logic              out_eof;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bsplit_top #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(16)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_len(in_len),
        .in_write(in_write), .in_sof(in_sof), .in_eof(in_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr), .out_len(out_len),
        .out_write(out_write), .out_sof(out_sof), .out_eof(out_eof)
    );

    // Stimulus table: address, length, write, sof, eof.
    localparam logic [ADDR_W-1:0] V_ADDR [NV] = '{32'h1000_0000, 32'h1000_0080, 32'h2000_0040,
        32'h2000_0100, 32'h3000_0000, 32'h3000_0200, 32'hFFFF_FFC0, 32'h4000_0000};
    localparam logic [LEN_W-1:0] V_LEN [NV] = '{4'd8, 4'd6, 4'd2, 4'd6, 4'd4, 4'd6, 4'd6, 4'd2};
    localparam logic V_WR  [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam logic V_SOF [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic V_EOF [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Compare the presented command against an expected one.
    task automatic chk_cmd(input string req, input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                           input logic w, input logic s, input logic e);
        logic [63:0] act;
        logic [63:0] exp;
        act = {20'd0, out_valid, out_addr, out_len, out_write, out_sof, out_eof};
        exp = {20'd0, 1'b1, a, l, w, s, e};
        chk(act == exp, req, "command {valid,addr,len,wr,sof,eof}", act, exp);
    endtask

    task automatic drive(input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] l,
                         input logic w, input logic s, input logic e);
        in_valid = 1'b1; in_addr = a; in_len = l; in_write = w; in_sof = s; in_eof = e;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'd1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'd0);

        // Table walk with out_ready held high (R2, R3, R4, R6).
        for (int i = 0; i < NV; i++) begin
            drive(V_ADDR[i], V_LEN[i], V_WR[i], V_SOF[i], V_EOF[i]);
            chk(in_ready == 1'b1, "R2", "in_ready before accept", 64'(in_ready), 64'd1);
            @(posedge clk); @(negedge clk);
            in_valid = 1'b0;
            if (V_LEN[i] == 4'd6) begin
                chk_cmd("R3", V_ADDR[i], 4'd4, V_WR[i], V_SOF[i], 1'b0);
                @(posedge clk); @(negedge clk);
                chk_cmd("R6", V_ADDR[i] + 32'd64, 4'd2, V_WR[i], V_SOF[i], V_EOF[i]);
            end else begin
                chk_cmd("R2", V_ADDR[i], V_LEN[i], V_WR[i], V_SOF[i], V_EOF[i]);
            end
            @(posedge clk); @(negedge clk);
            chk(out_valid == 1'b0, "R4", "idle after last part", 64'(out_valid), 64'd0);
        end

        // Split under back-pressure (R5, R7, R8).
        out_ready = 1'b0;
        drive(32'h5000_0000, 4'd6, 1'b0, 1'b1, 1'b0);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk_cmd("R7", 32'h5000_0000, 4'd4, 1'b0, 1'b1, 1'b0);
            chk(in_ready == 1'b0, "R5", "in_ready during stalled head", 64'(in_ready), 64'd0);
            @(posedge clk); @(negedge clk);
        end
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R5", "in_ready while head is taken", 64'(in_ready), 64'd0);
        @(posedge clk); @(negedge clk);
        out_ready = 1'b0;
        #1;
        chk_cmd("R7", 32'h5000_0040, 4'd2, 1'b0, 1'b1, 1'b0);
        chk(in_ready == 1'b0, "R5", "in_ready during stalled tail", 64'(in_ready), 64'd0);
        out_ready = 1'b1;
        #1;
        chk(in_ready == 1'b1, "R8", "in_ready as tail is taken", 64'(in_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b0, "R8", "idle after tail", 64'(out_valid), 64'd0);

        // Back-to-back whole commands with no bubble (R8, R2).
        drive(32'h6000_0000, 4'd4, 1'b1, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        chk_cmd("R2", 32'h6000_0000, 4'd4, 1'b1, 1'b0, 1'b0);
        drive(32'h6000_1000, 4'd8, 1'b1, 1'b0, 1'b1);
        chk(in_ready == 1'b1, "R8", "in_ready while whole is taken", 64'(in_ready), 64'd1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        chk_cmd("R8", 32'h6000_1000, 4'd8, 1'b1, 1'b0, 1'b1);
        @(posedge clk); @(negedge clk);

        // Reset during a split drops the held command (R1).
        out_ready = 1'b0;
        drive(32'h7000_0000, 4'd6, 1'b1, 1'b0, 1'b1);
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after mid-split reset", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1", "in_ready after mid-split reset", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule